// File: doc/BRIEF.md
# Pipelined Dual-Mode CORDIC Engine

This block computes vector rotations using only shifts and adds. It performs one micro-rotation per pipeline stage, so it accepts a new sample on every clock. A per-sample mode bit selects how each sample is used:

- **Vectoring mode** turns the input vector onto the positive x axis. The output x carries the gain-scaled magnitude and the output z carries the phase.
- **Rotation mode** turns the input vector through the angle given on z. Polar-to-cartesian conversion is the rotation case with y at zero.

All values are two's complement. The angle code spans the half-open interval from minus pi to plus pi. Minus pi is the most negative z code, and a full turn maps onto the whole z code space.

Before the iterations, a pre-rotation stage moves the sample into the range where the iterations converge:

- In vectoring mode it uses the sign of x and y.
- In rotation mode it uses the top two bits of z.

After the iterations, an output stage adds back the quarter-turn offset that was recorded for vectoring samples. The outputs stay multiplied by the CORDIC processing gain, which is about 1.6468 for the default 14 iterations. The user must provide at least two bits of headroom on x and y. With the default 18-bit path, each input component must fit in 16 bits.

Top module: `cordic_engine`

## Requirements
- R1: A sample with `in_valid` high appears on the outputs with `out_valid` high exactly ITER+3 clock cycles later. Every accepted sample produces exactly one result, in the order the samples were accepted.
- R2: `out_mode` equals the `in_mode` of the sample being presented (0 = vectoring, 1 = rotation). Modes may change from one sample to the next.
- R3: In vectoring mode (`in_mode`=0, `in_z`=0), `out_x` equals K·sqrt(x²+y²) and `out_y` is near zero. K is the product of sqrt(1+2^-2i) for i from 0 to ITER-1.
- R4: In vectoring mode, `out_z` equals atan2(y,x) in all four quadrants and on the axes, with pi mapped to 2^(ZW-1). The result is taken modulo 2^ZW, so a phase of plus pi reads as the code -2^(ZW-1).
- R5: In rotation mode (`in_mode`=1), `out_x` = K·(x·cos θ − y·sin θ) and `out_y` = K·(x·sin θ + y·cos θ), where θ = `in_z`·pi/2^(ZW-1). This holds for every angle code, including -2^(ZW-1). `out_z` is left as a residual near zero.
- R6: For polar-to-cartesian use (rotation mode with `in_y` = 0), `out_x` and `out_y` are K·r·cos θ and K·r·sin θ, with r = `in_x`.
- R7: A synchronous active-high `rst` clears every pipeline stage. One cycle after reset is sampled, `out_valid` is low and all outputs are zero. Samples that were in flight when reset was applied never emerge.
- R8: Inputs presented while `in_valid` is low are ignored and never produce `out_valid`.
- R9: Samples presented on consecutive cycles come out on consecutive cycles, one result per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_mode | input | 1 | 0 = vectoring, 1 = rotation |
| in_x | input | XW | Signed x component |
| in_y | input | XW | Signed y component |
| in_z | input | ZW | Signed angle (zero in vectoring mode) |
| out_valid | output | 1 | Result qualifier |
| out_mode | output | 1 | Mode of the presented result |
| out_x | output | XW | Signed x result, gain-scaled |
| out_y | output | XW | Signed y result, gain-scaled |
| out_z | output | ZW | Phase (vectoring) or residual angle (rotation) |

## Verification
The assertions check the following properties on every clock:

- After pre-rotation, a vectoring sample has non-negative x and a rotation sample has a residual angle within a quarter turn.
- x never shrinks across a vectoring stage.
- Valid and mode move one stage per clock, and no valid appears from nothing.
- The rotation residual settles near zero.
- Reset empties the output.

Only the bench scenarios can show the following:

- Numeric accuracy against trigonometric reference values in every quadrant and on the axes.
- The exact ITER+3 latency and ordering under back-to-back traffic with interleaved modes.
- The wrap of a plus-pi phase.
- The flushing of in-flight samples by a mid-stream reset.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic {
        MODE_VECTOR = 1'b0,
        MODE_ROTATE = 1'b1
    } cordic_mode_e;

    // quarter-turn offset to restore at the output
    typedef enum logic [1:0] {
        QADJ_NONE = 2'd0,
        QADJ_ADD  = 2'd1,
        QADJ_SUB  = 2'd2
    } qadj_e;

    // atan(2^-idx) in a 32-bit angle code where pi = 2^31
    function automatic logic [31:0] atan_unit32(input int idx);
        case (idx)
            0:  return 32'd536870912;
            1:  return 32'd316933406;
            2:  return 32'd167458907;
            3:  return 32'd85004756;
            4:  return 32'd42667331;
            5:  return 32'd21354465;
            6:  return 32'd10679838;
            7:  return 32'd5340245;
            8:  return 32'd2670163;
            9:  return 32'd1335087;
            10: return 32'd667544;
            11: return 32'd333772;
            12: return 32'd166886;
            13: return 32'd83443;
            14: return 32'd41722;
            15: return 32'd20861;
            16: return 32'd10430;
            17: return 32'd5215;
            18: return 32'd2608;
            19: return 32'd1304;
            20: return 32'd652;
            21: return 32'd326;
            22: return 32'd163;
            23: return 32'd81;
            24: return 32'd41;
            25: return 32'd20;
            26: return 32'd10;
            27: return 32'd5;
            28: return 32'd3;
            29: return 32'd1;
            30: return 32'd1;
            default: return 32'd0;
        endcase
    endfunction

    // same constant rounded to a zw-bit angle code (pi = 2^(zw-1))
    function automatic logic [31:0] atan_code(input int idx, input int zw);
        logic [32:0] t;
        t = {1'b0, atan_unit32(idx)};
        if (zw >= 32) return t[31:0];
        t = t + (33'd1 << (31 - zw));
        t = t >> (32 - zw);
        return t[31:0];
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot
    import cordic_pkg::*;
#(
    parameter int XW = 18,
    parameter int ZW = 16,
    parameter int GB = 4,
    parameter int IW = 23
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  cordic_mode_e         in_mode,
    input  logic [XW-1:0]        in_x,
    input  logic [XW-1:0]        in_y,
    input  logic [ZW-1:0]        in_z,
    output logic                 out_valid,
    output cordic_mode_e         out_mode,
    output logic signed [IW-1:0] out_x,
    output logic signed [IW-1:0] out_y,
    output logic [ZW-1:0]        out_z,
    output qadj_e                out_qadj
);
    localparam int EXT = IW - XW - GB;
    localparam logic [ZW-1:0] QUARTER = ZW'(1) << (ZW - 2);

    logic signed [IW-1:0] xe, ye, nx, ny;
    logic [ZW-1:0]        nz;
    qadj_e                nq;

    always_comb begin
        xe = $signed({{EXT{in_x[XW-1]}}, in_x, {GB{1'b0}}});
        ye = $signed({{EXT{in_y[XW-1]}}, in_y, {GB{1'b0}}});
        nx = xe;
        ny = ye;
        nz = in_z;
        nq = QADJ_NONE;
        if (in_mode == MODE_VECTOR) begin
            if (xe < 0) begin
                if (ye >= 0) begin
                    nx = ye;
                    ny = -xe;
                    nq = QADJ_ADD;
                end else begin
                    nx = -ye;
                    ny = xe;
                    nq = QADJ_SUB;
                end
            end
        end else begin
            case (in_z[ZW-1:ZW-2])
                2'b01: begin
                    nx = -ye;
                    ny = xe;
                    nz = in_z - QUARTER;
                end
                2'b10: begin
                    nx = ye;
                    ny = -xe;
                    nz = in_z + QUARTER;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mode  <= MODE_VECTOR;
            out_x     <= '0;
            out_y     <= '0;
            out_z     <= '0;
            out_qadj  <= QADJ_NONE;
        end else begin
            out_valid <= in_valid;
            out_mode  <= in_mode;
            out_x     <= nx;
            out_y     <= ny;
            out_z     <= nz;
            out_qadj  <= nq;
        end
    end

    // R4: a vectoring sample leaves pre-rotation in the right half plane
    assert_vec_right_half_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == MODE_VECTOR) |-> !out_x[IW-1]);

    // R5: a rotation sample leaves pre-rotation with |angle| within a quarter turn
    assert_rot_quarter_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == MODE_ROTATE) |-> (out_z[ZW-1] == out_z[ZW-2]));

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int IW    = 23,
    parameter int ZW    = 16,
    parameter int SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  cordic_mode_e         in_mode,
    input  logic signed [IW-1:0] in_x,
    input  logic signed [IW-1:0] in_y,
    input  logic [ZW-1:0]        in_z,
    input  qadj_e                in_qadj,
    output logic                 out_valid,
    output cordic_mode_e         out_mode,
    output logic signed [IW-1:0] out_x,
    output logic signed [IW-1:0] out_y,
    output logic [ZW-1:0]        out_z,
    output qadj_e                out_qadj
);
    localparam logic [31:0]   ANG32 = atan_code(SHIFT, ZW);
    localparam logic [ZW-1:0] ANG   = ANG32[ZW-1:0];

    logic signed [IW-1:0] xs, ys, nx, ny;
    logic [ZW-1:0]        nz;
    logic                 turn_ccw;

    always_comb begin
        xs = in_x >>> SHIFT;
        ys = in_y >>> SHIFT;
        turn_ccw = (in_mode == MODE_ROTATE) ? ~in_z[ZW-1] : in_y[IW-1];
        if (turn_ccw) begin
            nx = in_x - ys;
            ny = in_y + xs;
            nz = in_z - ANG;
        end else begin
            nx = in_x + ys;
            ny = in_y - xs;
            nz = in_z + ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mode  <= MODE_VECTOR;
            out_x     <= '0;
            out_y     <= '0;
            out_z     <= '0;
            out_qadj  <= QADJ_NONE;
        end else begin
            out_valid <= in_valid;
            out_mode  <= in_mode;
            out_x     <= nx;
            out_y     <= ny;
            out_z     <= nz;
            out_qadj  <= in_qadj;
        end
    end

    // R3: in vectoring mode each micro-rotation can only lengthen x
    assert_vec_x_grows_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_VECTOR) |=> (out_x >= $past(in_x)));

    // R2: valid and mode advance one stage per clock
    assert_mode_carried_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_mode == $past(in_mode)));

    // R8: no valid appears without one upstream
    assert_no_ghost_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/cordic_postcorr.sv
module cordic_postcorr
    import cordic_pkg::*;
#(
    parameter int XW   = 18,
    parameter int ZW   = 16,
    parameter int GB   = 4,
    parameter int IW   = 23,
    parameter int ITER = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  cordic_mode_e         in_mode,
    input  logic signed [IW-1:0] in_x,
    input  logic signed [IW-1:0] in_y,
    input  logic [ZW-1:0]        in_z,
    input  qadj_e                in_qadj,
    output logic                 out_valid,
    output logic                 out_mode,
    output logic [XW-1:0]        out_x,
    output logic [XW-1:0]        out_y,
    output logic [ZW-1:0]        out_z
);
    localparam logic [ZW-1:0] QUARTER = ZW'(1) << (ZW - 2);
    localparam logic [31:0]   LAST32  = atan_code(ITER - 1, ZW);
    localparam int            SETTLE  = int'(LAST32) + ITER;

    logic [ZW-1:0] zfix;

    always_comb begin
        case (in_qadj)
            QADJ_ADD: zfix = in_z + QUARTER;
            QADJ_SUB: zfix = in_z - QUARTER;
            default:  zfix = in_z;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mode  <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_z     <= '0;
        end else begin
            out_valid <= in_valid;
            out_mode  <= (in_mode == MODE_ROTATE);
            out_x     <= in_x[GB+XW-1:GB];
            out_y     <= in_y[GB+XW-1:GB];
            out_z     <= zfix;
        end
    end

    // R7: reset empties the output register
    assert_reset_flush_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_x == '0 && out_y == '0 && out_z == '0));

    // R5: the rotation angle has been driven to a small residual
    assert_rot_settled_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode) |->
            ($signed(out_z) <= SETTLE && $signed(out_z) >= -SETTLE));

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
    import cordic_pkg::*;
#(
    parameter int XW   = 18,
    parameter int ZW   = 16,
    parameter int ITER = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_mode,
    input  logic [XW-1:0] in_x,
    input  logic [XW-1:0] in_y,
    input  logic [ZW-1:0] in_z,
    output logic          out_valid,
    output logic          out_mode,
    output logic [XW-1:0] out_x,
    output logic [XW-1:0] out_y,
    output logic [ZW-1:0] out_z
);
    localparam int GB = $clog2(ITER);
    localparam int IW = XW + GB + 1;

    // capture register
    logic          cap_v;
    cordic_mode_e  cap_m;
    logic [XW-1:0] cap_x, cap_y;
    logic [ZW-1:0] cap_z;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_v <= 1'b0;
            cap_m <= MODE_VECTOR;
            cap_x <= '0;
            cap_y <= '0;
            cap_z <= '0;
        end else begin
            cap_v <= in_valid;
            cap_m <= cordic_mode_e'(in_mode);
            cap_x <= in_x;
            cap_y <= in_y;
            cap_z <= in_z;
        end
    end

    logic                 pv [0:ITER];
    cordic_mode_e         pm [0:ITER];
    logic signed [IW-1:0] px [0:ITER];
    logic signed [IW-1:0] py [0:ITER];
    logic [ZW-1:0]        pz [0:ITER];
    qadj_e                pq [0:ITER];

    cordic_prerot #(.XW(XW), .ZW(ZW), .GB(GB), .IW(IW)) u_prerot (
        .clk      (clk),
        .rst      (rst),
        .in_valid (cap_v),
        .in_mode  (cap_m),
        .in_x     (cap_x),
        .in_y     (cap_y),
        .in_z     (cap_z),
        .out_valid(pv[0]),
        .out_mode (pm[0]),
        .out_x    (px[0]),
        .out_y    (py[0]),
        .out_z    (pz[0]),
        .out_qadj (pq[0])
    );

    for (genvar i = 0; i < ITER; i++) begin : g_stage
        cordic_stage #(.IW(IW), .ZW(ZW), .SHIFT(i)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_valid (pv[i]),
            .in_mode  (pm[i]),
            .in_x     (px[i]),
            .in_y     (py[i]),
            .in_z     (pz[i]),
            .in_qadj  (pq[i]),
            .out_valid(pv[i+1]),
            .out_mode (pm[i+1]),
            .out_x    (px[i+1]),
            .out_y    (py[i+1]),
            .out_z    (pz[i+1]),
            .out_qadj (pq[i+1])
        );
    end

    cordic_postcorr #(.XW(XW), .ZW(ZW), .GB(GB), .IW(IW), .ITER(ITER)) u_post (
        .clk      (clk),
        .rst      (rst),
        .in_valid (pv[ITER]),
        .in_mode  (pm[ITER]),
        .in_x     (px[ITER]),
        .in_y     (py[ITER]),
        .in_z     (pz[ITER]),
        .in_qadj  (pq[ITER]),
        .out_valid(out_valid),
        .out_mode (out_mode),
        .out_x    (out_x),
        .out_y    (out_y),
        .out_z    (out_z)
    );

endmodule

// File: tb/cordic_engine_tb.sv
`timescale 1ns/1ps
module cordic_engine_tb;
    localparam int  XW    = 18;
    localparam int  ZW    = 16;
    localparam int  ITER  = 14;
    localparam int  LAT   = ITER + 3;
    localparam real PI    = 3.14159265358979;
    localparam real TOLXY = 32.0;
    localparam real TOLZ  = 12.0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_mode = 1'b0;
    logic [XW-1:0] in_x = '0;
    logic [XW-1:0] in_y = '0;
    logic [ZW-1:0] in_z = '0;
    logic          out_valid, out_mode;
    logic [XW-1:0] out_x, out_y;
    logic [ZW-1:0] out_z;

    cordic_engine #(.XW(XW), .ZW(ZW), .ITER(ITER)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_x(in_x), .in_y(in_y), .in_z(in_z), .out_valid(out_valid),
        .out_mode(out_mode), .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        real   ex, ey, ez;
        logic  mode;
        int    stamp;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   compared = 0;
    int   mismatched = 0;
    int   ghosts = 0;
    real  kgain;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real zwrap(input real d);
        real r = d;
        while (r >= 2.0 ** (ZW - 1)) r = r - 2.0 ** ZW;
        while (r < -(2.0 ** (ZW - 1))) r = r + 2.0 ** ZW;
        return r;
    endfunction

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic send(input int x, input int y, input int z, input logic m, input string tag);
        exp_t e;
        real th;
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = m;
        in_x     = x[XW-1:0];
        in_y     = y[XW-1:0];
        in_z     = z[ZW-1:0];
        if (!m) begin
            e.ex = kgain * $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
            e.ey = 0.0;
            e.ez = $atan2(real'(y), real'(x)) * (2.0 ** (ZW - 1)) / PI;
        end else begin
            th = real'(z) * PI / (2.0 ** (ZW - 1));
            e.ex = kgain * (real'(x) * $cos(th) - real'(y) * $sin(th));
            e.ey = kgain * (real'(x) * $sin(th) + real'(y) * $cos(th));
            e.ez = 0.0;
        end
        e.mode  = m;
        e.stamp = cyc;
        e.tag   = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n, input bit junk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (junk) begin
                in_x    = XW'(k * 7919);
                in_y    = XW'(k * 104729);
                in_z    = ZW'(k * 4099);
                in_mode = k[0];
            end
        end
    endtask

    task automatic check(input bit ok, input string msg);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: compare each result with the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                ghosts++;
            end else begin
                exp_t e;
                real ax, ay, az;
                int  lat;
                bit  ok;
                e   = sbq.pop_front();
                ax  = real'(int'($signed(out_x)));
                ay  = real'(int'($signed(out_y)));
                az  = real'(int'($signed(out_z)));
                lat = cyc - e.stamp;
                ok  = (lat == LAT) && (out_mode == e.mode) &&
                      (absr(ax - e.ex) <= TOLXY) && (absr(ay - e.ey) <= TOLXY) &&
                      (absr(zwrap(az - e.ez)) <= TOLZ);
                check(ok, $sformatf("%s R1/R2 lat=%0d exp %0d mode=%0b exp %0b x=%0.1f exp %0.1f y=%0.1f exp %0.1f z=%0.1f exp %0.1f",
                      e.tag, lat, LAT, out_mode, e.mode, ax, e.ex, ay, e.ey, az, e.ez));
            end
        end
    end

    initial begin
        kgain = 1.0;
        for (int i = 0; i < ITER; i++) kgain = kgain * $sqrt(1.0 + 2.0 ** (-2 * i));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check(!out_valid && out_x == '0 && out_y == '0 && out_z == '0,
              $sformatf("R7 reset state valid=%0b x=%0h y=%0h z=%0h exp all 0", out_valid, out_x, out_y, out_z));

        // R3, R4: vectoring in all quadrants and on axes
        send( 20000,   5000, 0, 1'b0, "R3 vec q1");
        send(-20000,   5000, 0, 1'b0, "R4 vec q2");
        send(-12000, -25000, 0, 1'b0, "R4 vec q3");
        send(  9000, -30000, 0, 1'b0, "R4 vec q4");
        send(     0,  20000, 0, 1'b0, "R4 vec +y axis");
        send(     0, -20000, 0, 1'b0, "R4 vec -y axis");
        send(-20000,      0, 0, 1'b0, "R4 vec -x axis wrap");
        send( 32000,      0, 0, 1'b0, "R3 vec +x axis");
        idle(LAT + 2, 1'b0);

        // R5: general rotation, full angle range
        send(15000, -7000,      0, 1'b1, "R5 rot zero");
        send(15000, -7000,  10000, 1'b1, "R5 rot q1");
        send(15000, -7000,  16384, 1'b1, "R5 rot +pi/2");
        send(15000, -7000,  16383, 1'b1, "R5 rot below pi/2");
        send(15000, -7000,  30000, 1'b1, "R5 rot q2");
        send(15000, -7000, -16384, 1'b1, "R5 rot -pi/2");
        send(15000, -7000, -20000, 1'b1, "R5 rot q3");
        send(15000, -7000, -32768, 1'b1, "R5 rot -pi");
        // R6: polar to cartesian
        send(25000, 0,   5461, 1'b1, "R6 polar 30deg");
        send(25000, 0, -27307, 1'b1, "R6 polar -150deg");
        send(18000, 0,  24576, 1'b1, "R6 polar 135deg");
        idle(LAT + 2, 1'b0);

        // R9 + R2: back-to-back with interleaved modes
        for (int k = 0; k < 16; k++) begin
            if (k[0])
                send(3000 + k * 900, -2000 + k * 500, -30000 + k * 4000, 1'b1, "R9 b2b rot");
            else
                send(-4000 + k * 700, 9000 - k * 1300, 0, 1'b0, "R9 b2b vec");
        end
        idle(LAT + 2, 1'b0);
        check(sbq.size() == 0, $sformatf("R1 pending results %0d exp 0", sbq.size()));

        // R8: junk inputs with valid low
        begin
            int g0 = ghosts;
            idle(LAT + 6, 1'b1);
            check(ghosts == g0, $sformatf("R8 outputs during invalid input %0d exp 0", ghosts - g0));
        end

        // R7: mid-stream reset flushes in-flight samples
        send(10000, 10000, 0, 1'b0, "R7 flushed");
        send(10000, 10000, 0, 1'b0, "R7 flushed");
        send(10000, 10000, 0, 1'b0, "R7 flushed");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        sbq.delete();
        rst = 1'b0;
        begin
            int g0 = ghosts;
            idle(LAT + 6, 1'b0);
            check(ghosts == g0, $sformatf("R7 flushed samples emerged %0d exp 0", ghosts - g0));
        end

        // sample after reset still correct
        send(-7000, 21000, 0, 1'b0, "R4 vec after reset");
        idle(LAT + 2, 1'b0);
        check(sbq.size() == 0 && ghosts == 0,
              $sformatf("R1/R8 pending %0d unexpected %0d exp 0 0", sbq.size(), ghosts));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog expired actual hung exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule